// File: doc/BRIEF.md
# Parallel Flash Command State Machine

This block models a parallel NOR flash device that is driven through a command register. Every bus write is decoded either as a command byte or as a data cycle of a command that is already in flight, and every bus read returns array contents or a status/identification byte, depending on the mode the machine is in. The storage is a small internal array built from one byte-wide RAM per bus lane, so the array maps onto block RAM.

Supported operations are read-array mode, single-word program, sector erase with a confirm cycle, buffered program with a word count, status read and clear, identifier read, query read, and a lock/unlock sequence that is decoded but not enforced. Erase runs as a sweep that writes one bus-wide row of 0xFF per clock over the whole sector. While the sweep runs, the ready bit of the status byte reads low. A level input marks the array as read-only; program and erase requests are then refused and an error bit is set instead.

The bus is a plain synchronous interface: one-cycle write and read strobes, a byte address, a size code and write data. Read data comes back two clocks after the read strobe, qualified by a valid pulse.

Top module: `pfl_cmd_flash`

## Requirements
- R1: After synchronous reset, the machine is in read-array mode, the status byte is 0x80 and `rd_valid` is low. The array contents are not affected by reset.
- R2: A read strobe produces `rd_valid` and `rd_data` exactly two clocks later. Size code 0, 1 or 2 selects 1, 2 or 4 bytes at the naturally aligned address, zero-extended in `rd_data`. With `BIG_ENDIAN`=0 the lowest address maps to `rd_data[7:0]`; with `BIG_ENDIAN`=1 it maps to the most significant byte of the access. Writes use the same mapping.
- R3: Command 0x10 or 0x40 arms a program. The next write stores its data, with its size, at its address. The machine then returns status on reads, with bit 7 (0x80) set.
- R4: Command 0x20 or 0x28 followed by 0xD0 fills the whole sector containing the address with 0xFF, writing one bus row per clock. Status bit 7 reads 0 during the sweep and 1 after it, and the machine then stays in status mode.
- R5: An erase armed by 0x20 or 0x28 and followed by 0xFF or any other value other than 0xD0 is abandoned. The machine returns to read-array mode and the array is unchanged.
- R6: Status bits 7 (ready), 5 (0x20, erase error) and 4 (0x10, program error) accumulate. Command 0x50 clears the whole status byte to 0x00, and reads then return status.
- R7: Command 0xE8 sets the ready bit. The next write gives the word count minus one, taking only its low 8×`DEV_BYTES` bits. That many plus one data writes are stored at their own addresses, and a following 0xD0 ends the sequence in status mode. Reads return status throughout the sequence.
- R8: Command 0x60 followed by 0xD0 or 0x01 enters status mode with the ready bit set. Any other second value returns to read-array mode. Neither case changes the array.
- R9: 0xFF and 0xF0 select read-array mode, and 0x70 selects status mode. 0x90 selects identifier mode: at index = address >> log2(`BANK_BYTES`), index 0 returns `MFR_CODE`, 1 returns `DEV_CODE` and other indices return 0. 0x98 selects query mode: index 0x10, 0x11 and 0x12 return 0x51, 0x52 and 0x59; 0x13 returns 0x01; 0x27 returns `ADDR_W`; 0x2D returns the sector count minus one; other indices return 0. Any unrecognised first-cycle command selects read-array mode and leaves the array unchanged.
- R10: In every mode other than read-array, the response byte is placed in each byte k of the access with k mod `DEV_BYTES` = 0; the other bytes are zero.
- R11: While `array_ro` is high, a program data write sets 0x10 and an erase confirm sets 0x20, each together with 0x80, and the array is not modified. The refused erase sets ready at once, with no sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per bus write |
| bus_rd | input | 1 | Read strobe, one cycle per bus read |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| bus_wdata | input | 8*BANK_BYTES | Write data; command byte in bits 7:0 |
| array_ro | input | 1 | Array is read-only: program and erase are refused |
| rd_data | output | 8*BANK_BYTES | Read response, registered |
| rd_valid | output | 1 | Marks `rd_data` as valid, two clocks after `bus_rd` |

## Verification
The hardest state to observe from the ports is the middle of an erase sweep, since it lasts only one sector's worth of rows. The bench therefore issues status reads right after the confirm and keeps polling until the ready bit returns, checking that the first poll shows the busy value. The refused-operation path is reached by holding `array_ro` high through a program and an erase, then clearing the status and reading the untouched array back. Byte order is covered by a second instance with the opposite endian setting fed by the same stimulus.

// File: rtl/pfl_pkg.sv
package pfl_pkg;

  typedef enum logic [3:0] {
    S_ARRAY, S_STATUS, S_IDENT, S_QUERY, S_PROG,
    S_ERASE_ARM, S_ERASE_RUN, S_LOCK_ARM, S_BUF_CNT, S_BUF_DATA, S_BUF_CONF
  } fsm_e;

  typedef enum logic [1:0] {RD_ARRAY, RD_STATUS, RD_IDENT, RD_QUERY} rdsel_e;

  localparam logic [7:0] ST_READY     = 8'h80;
  localparam logic [7:0] ST_ERASE_ERR = 8'h20;
  localparam logic [7:0] ST_PROG_ERR  = 8'h10;

  function automatic logic [7:0] ident_byte(input logic [7:0] idx,
                                            input logic [7:0] mfr,
                                            input logic [7:0] dev);
    case (idx)
      8'h00:   return mfr;
      8'h01:   return dev;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] query_byte(input logic [7:0] idx,
                                            input logic [7:0] log2_bytes,
                                            input logic [7:0] sec_m1);
    case (idx)
      8'h10:   return 8'h51;
      8'h11:   return 8'h52;
      8'h12:   return 8'h59;
      8'h13:   return 8'h01;
      8'h27:   return log2_bytes;
      8'h2D:   return sec_m1;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/pfl_lane_ram.sv
module pfl_lane_ram #(
  parameter int ROWS = 256,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [RW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pfl_cmd_fsm.sv
module pfl_cmd_fsm
  import pfl_pkg::*;
#(
  parameter int SEC_W = 2,
  parameter int SR_W  = 6,
  parameter int CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr,
  input  logic [7:0]            cmd,
  input  logic [CNT_W-1:0]      cnt_in,
  input  logic [SEC_W-1:0]      sec_in,
  input  logic                  array_ro,
  output logic                  prog_we,
  output logic                  sweep_we,
  output logic [SEC_W+SR_W-1:0] sweep_row,
  output logic [7:0]            status_q,
  output rdsel_e                rd_sel
);
  fsm_e             state;
  logic [CNT_W-1:0] cnt;
  logic [SR_W-1:0]  sweep_cnt;
  logic [SEC_W-1:0] sec_q;
  logic             idle;

  assign idle = (state == S_ARRAY) || (state == S_STATUS) ||
                (state == S_IDENT) || (state == S_QUERY);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_ARRAY;
      status_q  <= ST_READY;
      cnt       <= '0;
      sweep_cnt <= '0;
      sec_q     <= '0;
    end else if (state == S_ERASE_RUN) begin
      sweep_cnt <= sweep_cnt + 1'b1;
      if (&sweep_cnt) begin
        state    <= S_STATUS;
        status_q <= status_q | ST_READY;
      end
    end else if (wr) begin
      case (state)
        S_PROG: begin
          status_q <= status_q | ST_READY | (array_ro ? ST_PROG_ERR : 8'h00);
          state    <= S_STATUS;
        end
        S_ERASE_ARM: begin
          if (cmd != 8'hD0) begin
            state <= S_ARRAY;
          end else if (array_ro) begin
            status_q <= status_q | ST_READY | ST_ERASE_ERR;
            state    <= S_STATUS;
          end else begin
            status_q  <= status_q & ~ST_READY;
            sec_q     <= sec_in;
            sweep_cnt <= '0;
            state     <= S_ERASE_RUN;
          end
        end
        S_LOCK_ARM: begin
          if (cmd == 8'hD0 || cmd == 8'h01) begin
            status_q <= status_q | ST_READY;
            state    <= S_STATUS;
          end else begin
            state <= S_ARRAY;
          end
        end
        S_BUF_CNT: begin
          cnt   <= cnt_in;
          state <= S_BUF_DATA;
        end
        S_BUF_DATA: begin
          if (array_ro) status_q <= status_q | ST_PROG_ERR;
          if (cnt == '0) state <= S_BUF_CONF;
          else           cnt   <= cnt - 1'b1;
        end
        S_BUF_CONF: begin
          status_q <= status_q | ST_READY;
          state    <= (cmd == 8'hD0) ? S_STATUS : S_ARRAY;
        end
        default: begin
          case (cmd)
            8'h10, 8'h40: state <= S_PROG;
            8'h20, 8'h28: state <= S_ERASE_ARM;
            8'h50: begin
              status_q <= 8'h00;
              state    <= S_STATUS;
            end
            8'h60: state <= S_LOCK_ARM;
            8'h70: state <= S_STATUS;
            8'h90: state <= S_IDENT;
            8'h98: state <= S_QUERY;
            8'hE8: begin
              status_q <= status_q | ST_READY;
              state    <= S_BUF_CNT;
            end
            default: state <= S_ARRAY;
          endcase
        end
      endcase
    end
  end

  assign prog_we   = wr && !array_ro && ((state == S_PROG) || (state == S_BUF_DATA));
  assign sweep_we  = (state == S_ERASE_RUN);
  assign sweep_row = {sec_q, sweep_cnt};

  always_comb begin
    case (state)
      S_ARRAY: rd_sel = RD_ARRAY;
      S_IDENT: rd_sel = RD_IDENT;
      S_QUERY: rd_sel = RD_QUERY;
      default: rd_sel = RD_STATUS;
    endcase
  end

  AST_SWEEP_BUSY: assert property (@(posedge clk) disable iff (rst)
    (state == S_ERASE_RUN) |-> !status_q[7]); // R4

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    !(wr && idle && cmd == 8'h50) |=>
      ((status_q & 8'h30) & $past(status_q & 8'h30)) == $past(status_q & 8'h30)); // R6

  AST_BUF_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
    (state == S_BUF_DATA && wr && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R7

  AST_RO_PROG_ERR: assert property (@(posedge clk) disable iff (rst)
    (wr && array_ro && (state == S_PROG || state == S_BUF_DATA)) |=> status_q[4]); // R11
endmodule

// File: rtl/pfl_rsp_fmt.sv
module pfl_rsp_fmt #(
  parameter int LANES      = 4,
  parameter int DEV_BYTES  = 1,
  parameter bit BIG_ENDIAN = 1'b0,
  localparam int LB        = $clog2(LANES)
) (
  input  logic               is_array,
  input  logic [1:0]         size,
  input  logic [LB-1:0]      off,
  input  logic [8*LANES-1:0] row,
  input  logic [7:0]         info,
  output logic [8*LANES-1:0] dout
);
  int n, base, src;

  always_comb begin
    dout = '0;
    n    = 1 << size;
    base = int'(off) & ~(n - 1);
    src  = 0;
    for (int k = 0; k < LANES; k++) begin
      if (k < n) begin
        if (is_array) begin
          src = BIG_ENDIAN ? (base + n - 1 - k) : (base + k);
          if (src < LANES) dout[8*k +: 8] = row[8*src +: 8];
        end else if ((k % DEV_BYTES) == 0) begin
          dout[8*k +: 8] = info;
        end
      end
    end
  end
endmodule

// File: rtl/pfl_cmd_flash.sv
module pfl_cmd_flash
  import pfl_pkg::*;
#(
  parameter int         ADDR_W       = 10,
  parameter int         BANK_BYTES   = 4,
  parameter int         DEV_BYTES    = 1,
  parameter int         SECTOR_BYTES = 256,
  parameter bit         BIG_ENDIAN   = 1'b0,
  parameter logic [7:0] MFR_CODE     = 8'hC2,
  parameter logic [7:0] DEV_CODE     = 8'h7E,
  localparam int        DATA_W       = 8 * BANK_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              array_ro,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int LANES    = BANK_BYTES;
  localparam int LB       = $clog2(LANES);
  localparam int ROWS     = (1 << ADDR_W) / LANES;
  localparam int RW       = ADDR_W - LB;
  localparam int SR_W     = $clog2(SECTOR_BYTES / LANES);
  localparam int SEC_W    = RW - SR_W;
  localparam int SECTORS  = (1 << ADDR_W) / SECTOR_BYTES;
  localparam int CNT_W    = 8 * DEV_BYTES;

  logic          prog_we, sweep_we;
  logic [RW-1:0] sweep_row;
  logic [7:0]    status;
  rdsel_e        rd_sel;

  pfl_cmd_fsm #(.SEC_W(SEC_W), .SR_W(SR_W), .CNT_W(CNT_W)) fsm_i (
    .clk      (clk),
    .rst      (rst),
    .wr       (bus_wr),
    .cmd      (bus_wdata[7:0]),
    .cnt_in   (bus_wdata[CNT_W-1:0]),
    .sec_in   (bus_addr[ADDR_W-1 -: SEC_W]),
    .array_ro (array_ro),
    .prog_we  (prog_we),
    .sweep_we (sweep_we),
    .sweep_row(sweep_row),
    .status_q (status),
    .rd_sel   (rd_sel)
  );

  logic [DATA_W-1:0] row_rd;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    int         n_w, base_w, k_w;
    logic       hit;
    logic [7:0] wbyte;

    always_comb begin
      n_w    = 1 << bus_size;
      base_w = int'(bus_addr[LB-1:0]) & ~(n_w - 1);
      hit    = (l >= base_w) && (l < base_w + n_w);
      k_w    = BIG_ENDIAN ? (base_w + n_w - 1 - l) : (l - base_w);
      if (!hit || k_w < 0 || k_w >= LANES) k_w = 0;
      wbyte  = bus_wdata[8*k_w +: 8];
    end

    pfl_lane_ram #(.ROWS(ROWS)) ram_i (
      .clk  (clk),
      .we   (sweep_we || (prog_we && hit)),
      .waddr(sweep_we ? sweep_row : bus_addr[ADDR_W-1:LB]),
      .wdata(sweep_we ? 8'hFF : wbyte),
      .raddr(bus_addr[ADDR_W-1:LB]),
      .rdata(row_rd[8*l +: 8])
    );
  end

  logic [7:0] idx, info;
  assign idx = 8'(bus_addr >> LB);

  always_comb begin
    case (rd_sel)
      RD_IDENT: info = ident_byte(idx, MFR_CODE, DEV_CODE);
      RD_QUERY: info = query_byte(idx, 8'(ADDR_W), 8'(SECTORS - 1));
      default:  info = status;
    endcase
  end

  logic              p1, arr_q;
  logic [1:0]        sz_q;
  logic [LB-1:0]     off_q;
  logic [7:0]        info_q;
  logic [DATA_W-1:0] fmt_out;

  pfl_rsp_fmt #(.LANES(LANES), .DEV_BYTES(DEV_BYTES), .BIG_ENDIAN(BIG_ENDIAN)) fmt_i (
    .is_array(arr_q),
    .size    (sz_q),
    .off     (off_q),
    .row     (row_rd),
    .info    (info_q),
    .dout    (fmt_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      p1       <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      arr_q    <= 1'b0;
      sz_q     <= '0;
      off_q    <= '0;
      info_q   <= '0;
    end else begin
      p1       <= bus_rd;
      rd_valid <= p1;
      if (bus_rd) begin
        arr_q  <= (rd_sel == RD_ARRAY);
        sz_q   <= bus_size;
        off_q  <= bus_addr[LB-1:0];
        info_q <= info;
      end
      if (p1) rd_data <= fmt_out;
    end
  end

  AST_RD_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
    bus_rd |-> ##2 rd_valid); // R2
endmodule

// File: tb/pfl_cmd_flash_tb_top.sv
`timescale 1ns/1ps
module pfl_cmd_flash_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, array_ro = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_le, rd_be;
  logic        vld_le, vld_be;
  int          checks = 0, failures = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  pfl_cmd_flash dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .array_ro(array_ro),
    .rd_data(rd_le), .rd_valid(vld_le));

  pfl_cmd_flash #(.BIG_ENDIAN(1'b1)) dut_be (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .array_ro(array_ro),
    .rd_data(rd_be), .rd_valid(vld_be));

  typedef struct packed {
    logic        is_rd;
    logic [9:0]  addr;
    logic [1:0]  sz;
    logic [31:0] val;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 50;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 10'h000, 2'd0, 32'h000000FF, 4'd9},  // R9 read-array
    '{1'b1, 10'h000, 2'd2, 32'hFFFFFFFF, 4'd4},  // R4 erased
    '{1'b0, 10'h000, 2'd0, 32'h00000040, 4'd3},  // R3 program
    '{1'b0, 10'h004, 2'd2, 32'h11223344, 4'd3},
    '{1'b1, 10'h004, 2'd2, 32'h80808080, 4'd10}, // R10 replicated status
    '{1'b0, 10'h000, 2'd0, 32'h000000FF, 4'd9},
    '{1'b1, 10'h004, 2'd2, 32'h11223344, 4'd2},  // R2 sizes
    '{1'b1, 10'h005, 2'd0, 32'h00000033, 4'd2},
    '{1'b1, 10'h006, 2'd1, 32'h00001122, 4'd2},
    '{1'b0, 10'h000, 2'd0, 32'h00000010, 4'd3},
    '{1'b0, 10'h008, 2'd1, 32'h0000BEEF, 4'd3},
    '{1'b0, 10'h000, 2'd0, 32'h000000FF, 4'd9},
    '{1'b1, 10'h008, 2'd2, 32'hFFFFBEEF, 4'd3},
    '{1'b0, 10'h000, 2'd0, 32'h00000090, 4'd9},  // R9 identifier
    '{1'b1, 10'h000, 2'd2, 32'hC2C2C2C2, 4'd10},
    '{1'b1, 10'h004, 2'd0, 32'h0000007E, 4'd9},
    '{1'b1, 10'h008, 2'd0, 32'h00000000, 4'd9},
    '{1'b0, 10'h000, 2'd0, 32'h00000098, 4'd9},  // R9 query
    '{1'b1, 10'h040, 2'd0, 32'h00000051, 4'd9},
    '{1'b1, 10'h044, 2'd0, 32'h00000052, 4'd9},
    '{1'b1, 10'h048, 2'd2, 32'h59595959, 4'd10},
    '{1'b1, 10'h09C, 2'd0, 32'h0000000A, 4'd9},
    '{1'b1, 10'h0B4, 2'd0, 32'h00000003, 4'd9},
    '{1'b0, 10'h000, 2'd0, 32'h00000070, 4'd9},
    '{1'b1, 10'h000, 2'd1, 32'h00008080, 4'd10},
    '{1'b0, 10'h000, 2'd0, 32'h00000033, 4'd9},  // unknown command
    '{1'b1, 10'h004, 2'd2, 32'h11223344, 4'd9},
    '{1'b0, 10'h000, 2'd0, 32'h00000060, 4'd8},  // R8 lock
    '{1'b0, 10'h000, 2'd0, 32'h00000001, 4'd8},
    '{1'b1, 10'h000, 2'd0, 32'h00000080, 4'd8},
    '{1'b0, 10'h000, 2'd0, 32'h00000060, 4'd8},
    '{1'b0, 10'h000, 2'd0, 32'h00000055, 4'd8},
    '{1'b1, 10'h004, 2'd2, 32'h11223344, 4'd8},
    '{1'b0, 10'h000, 2'd0, 32'h000000E8, 4'd7},  // R7 buffered
    '{1'b1, 10'h000, 2'd0, 32'h00000080, 4'd7},
    '{1'b0, 10'h000, 2'd1, 32'h00000101, 4'd7},
    '{1'b0, 10'h010, 2'd2, 32'hA1A2A3A4, 4'd7},
    '{1'b0, 10'h014, 2'd2, 32'hB1B2B3B4, 4'd7},
    '{1'b0, 10'h000, 2'd0, 32'h000000D0, 4'd7},
    '{1'b1, 10'h010, 2'd0, 32'h00000080, 4'd7},
    '{1'b0, 10'h000, 2'd0, 32'h000000FF, 4'd7},
    '{1'b1, 10'h010, 2'd2, 32'hA1A2A3A4, 4'd7},
    '{1'b1, 10'h014, 2'd2, 32'hB1B2B3B4, 4'd7},
    '{1'b1, 10'h018, 2'd2, 32'hFFFFFFFF, 4'd7},
    '{1'b0, 10'h000, 2'd0, 32'h00000020, 4'd5},  // R5 abandon
    '{1'b0, 10'h000, 2'd0, 32'h000000FF, 4'd5},
    '{1'b1, 10'h004, 2'd2, 32'h11223344, 4'd5},
    '{1'b0, 10'h000, 2'd0, 32'h00000028, 4'd5},
    '{1'b0, 10'h004, 2'd0, 32'h00000077, 4'd5},
    '{1'b1, 10'h004, 2'd2, 32'h11223344, 4'd5}
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [9:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [9:0] a, input logic [1:0] s,
                       output logic [31:0] le, output logic [31:0] be);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_size = s;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
    le = vld_le ? rd_le : 32'hDEADDEAD;
    be = vld_be ? rd_be : 32'hDEADDEAD;
  endtask

  task automatic erase_and_poll(input logic [7:0] arm, input logic [9:0] a);
    logic [31:0] le, be;
    int polls;
    do_wr(a, 2'd0, {24'h0, arm});
    do_wr(a, 2'd0, 32'hD0);
    do_rd(a, 2'd0, le, be);
    chk(4, le, 32'h00000000);             // R4 busy during sweep
    polls = 0;
    while (le != 32'h80 && polls < 200) begin
      do_rd(a, 2'd0, le, be);
      polls++;
    end
    chk(4, le, 32'h00000080);             // R4 ready after sweep
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    logic [31:0] le, be;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(1, {31'h0, vld_le}, 32'h0);       // R1 no valid after reset
    do_wr(10'h000, 2'd0, 32'h70);
    do_rd(10'h000, 2'd0, le, be);
    chk(1, le, 32'h00000080);             // R1 reset status

    erase_and_poll(8'h20, 10'h030);       // sector 0
    erase_and_poll(8'h28, 10'h1F0);       // sector 1
    do_wr(10'h000, 2'd0, 32'hFF);
    do_rd(10'h100, 2'd2, le, be);
    chk(4, le, 32'hFFFFFFFF);
    do_rd(10'h1FC, 2'd2, le, be);
    chk(4, le, 32'hFFFFFFFF);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].is_rd) begin
        do_rd(TBL[i].addr, TBL[i].sz, le, be);
        chk(int'(TBL[i].req), le, TBL[i].val);
      end else begin
        do_wr(TBL[i].addr, TBL[i].sz, TBL[i].val);
      end
    end

    // R2 byte order: same stimulus, opposite endian setting
    do_rd(10'h004, 2'd0, le, be);
    chk(2, le, 32'h00000044);
    chk(2, be, 32'h00000011);
    do_rd(10'h004, 2'd2, le, be);
    chk(2, be, 32'h11223344);

    // R11 and R6: refused program and erase, sticky bits, clear
    array_ro = 1'b1;
    do_wr(10'h000, 2'd0, 32'h40);
    do_wr(10'h004, 2'd2, 32'h00000000);
    do_rd(10'h000, 2'd0, le, be);
    chk(11, le, 32'h00000090);
    do_wr(10'h000, 2'd0, 32'h20);
    do_wr(10'h000, 2'd0, 32'hD0);
    do_rd(10'h000, 2'd0, le, be);
    chk(6, le, 32'h000000B0);             // R6 accumulate, R11 no sweep
    array_ro = 1'b0;
    do_wr(10'h000, 2'd0, 32'h50);
    do_rd(10'h000, 2'd0, le, be);
    chk(6, le, 32'h00000000);
    do_wr(10'h000, 2'd0, 32'hFF);
    do_rd(10'h004, 2'd2, le, be);
    chk(11, le, 32'h11223344);
    do_rd(10'h000, 2'd2, le, be);
    chk(11, le, 32'hFFFFFFFF);
    do_wr(10'h000, 2'd0, 32'h40);
    do_wr(10'h00C, 2'd0, 32'h5A);
    do_rd(10'h00C, 2'd0, le, be);
    chk(6, le, 32'h00000080);
    do_wr(10'h000, 2'd0, 32'hFF);
    do_rd(10'h00C, 2'd2, le, be);
    chk(3, le, 32'hFFFFFF5A);

    // R1: reset mid-run returns to read-array, array kept
    do_wr(10'h000, 2'd0, 32'h90);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    do_rd(10'h004, 2'd2, le, be);
    chk(1, le, 32'h11223344);

    done = 1'b1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end
endmodule